// File: doc/BRIEF.md
# Card punch word collector

This block sits between a data channel and the punching side of a card punch. A write select starts a card cycle. After a start delay the block clears its 24-word card image, asks the channel for a word, and then opens timed word slots. Each word the channel writes is stored as one half of one card row. At every slot the block checks that a word arrived since the previous slot. If none did, it raises a sticky I/O-check flag. It then requests the next word.

A card closes in three ways: the 24th word arrives, a word arrives carrying end-of-record, or the channel drops its connection. After the card closes, the block streams the image out as 72 columns, one per clock. Each column is given both as the raw 12-row pattern and as a 6-bit BCD code. It then waits a stop delay. If the channel is still connected, the next card begins. Otherwise the block goes idle.

The control is a four-state machine:
- IDLE: waits for select.
- START: times the start delay. On its last cycle it performs the card initialisation.
- DATA: accepts words and runs the slot timer.
- END: streams columns and times the stop delay.

The transitions are:
- select: IDLE to START.
- start-expired: START to DATA.
- close-on-full, close-on-record-end and close-on-disconnect: DATA to END.
- restart: END to START when still connected.
- release: END to IDLE when disconnected.

Top module: `punch_word_collector`

## Requirements
- R1: After reset, req_o, eor_o, ioc_o, ierr_o and col_valid_o are all low and the block is in IDLE.
- R2: A high sel_i in IDLE starts a card. req_o pulses exactly START_DLY cycles after the clock edge that sampled sel_i, with the image cleared and the write pointer at 0. sel_i in any other state is ignored.
- R3: A write in DATA stores wr_data_i at the current pointer, increments the pointer and marks the holding slot as filled.
- R4: The card closes, with a one-cycle eor_o pulse, on the write that fills word 23 or on any write with wr_eor_i high.
- R5: At each slot in DATA, a filled holding slot is emptied. An empty one sets ioc_o, which stays high until reset. Every slot pulses req_o.
- R6: After initialisation the first slot is SHORT_DLY counted cycles away. After each slot the next one is SHORT_DLY counted cycles away when the pointer is odd and LONG_DLY when it is even. The slot timer does not count in a cycle where a word is accepted.
- R7: If conn_i is low in a DATA cycle with no write, the card closes with the words received so far and no eor_o pulse.
- R8: After a close, the block waits STOP_DLY cycles. If conn_i is then high it restarts at START and initialises on the next edge. Otherwise it goes to IDLE and requests nothing more.
- R9: From the cycle after a close, col_valid_o is high for 72 cycles while col_idx_o runs 0..71. Bit r of col_bin_o is bit 35-(c mod 36) of word 2r+c/36. Bit 0 is row 9, bits 1..8 are rows 8..1, bit 9 is row 0, bit 10 is row 11 and bit 11 is row 12.
- R10: col_bcd_o is the OR of the weights of the punched rows: rows 1..9 give octal 1..11 (the digit), row 0 gives 020, row 11 gives 040 and row 12 gives 060. Multiple punches are never an error.
- R11: A write outside DATA is not stored and produces a one-cycle ierr_o pulse on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Write select strobe |
| wr_valid_i | input | 1 | Channel word write strobe |
| wr_data_i | input | 36 | Channel word |
| wr_eor_i | input | 1 | Word is last of its record |
| conn_i | input | 1 | Channel still connected |
| req_o | output | 1 | Word request pulse |
| eor_o | output | 1 | End-of-record pulse to the channel |
| ioc_o | output | 1 | Sticky I/O-check flag |
| ierr_o | output | 1 | Write outside the data phase |
| col_valid_o | output | 1 | Column stream valid |
| col_idx_o | output | 7 | Column number 0..71 |
| col_bin_o | output | 12 | Column row pattern |
| col_bcd_o | output | 6 | Column BCD code |

## Verification
The bench builds the block with START_DLY=20, STOP_DLY=90, SHORT_DLY=3 and LONG_DLY=7, and keeps the default 36-bit words and 24-word image because the column mapping depends on them. The short delays let full cards, record-end cards, restarts, missed slots and disconnects all run within a few thousand cycles. Small odd and even slot gaps can be measured exactly. The stop delay still exceeds the 72-cycle column stream.

// File: rtl/punch_pkg.sv
package punch_pkg;

    localparam int PUNCH_ROWS = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_END   = 2'd3
    } punch_state_e;

    // weight of one row bit of a column pattern in the BCD code
    function automatic logic [5:0] row_weight(input int idx);
        logic [5:0] w;
        if (idx <= 8)       w = 6'(9 - idx);   // digit rows 9..1
        else if (idx == 9)  w = 6'o20;         // zero row
        else if (idx == 10) w = 6'o40;         // eleven row
        else                w = 6'o60;         // twelve row
        return w;
    endfunction

endpackage

// File: rtl/pc_slot_timer.sv
module pc_slot_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         hold_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (!hold_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R6
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && hold_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pc_card_buffer.sv
module pc_card_buffer #(
    parameter int WORD_W = 36,
    parameter int NWORDS = 24,
    parameter int ROWS   = 12,
    localparam int HALVES = NWORDS / ROWS,
    localparam int COLS   = HALVES * WORD_W,
    localparam int WIW    = $clog2(NWORDS),
    localparam int CIW    = $clog2(COLS),
    localparam int BW     = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              we_i,
    input  logic [WIW-1:0]    widx_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [CIW-1:0]    col_i,
    output logic [ROWS-1:0]   rows_o
);
    logic [WORD_W-1:0] mem [NWORDS];
    logic [CIW-1:0]    grp_c;
    logic [BW-1:0]     bpos_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
        end else if (clr_i) begin
            for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
        end else if (we_i) begin
            mem[widx_i] <= wdata_i;
        end
    end

    // column c lives in word group c/WORD_W at bit WORD_W-1-(c mod WORD_W)
    always_comb begin
        grp_c  = CIW'(int'(col_i) / WORD_W);
        bpos_c = BW'(WORD_W - 1 - (int'(col_i) % WORD_W));
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign rows_o[r] = mem[WIW'(r * HALVES) + WIW'(grp_c)][bpos_c];
    end

    // R3
    widx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (int'(widx_i) < NWORDS));

endmodule

// File: rtl/pc_bcd_encoder.sv
module pc_bcd_encoder
    import punch_pkg::*;
(
    input  logic [PUNCH_ROWS-1:0] col_i,
    output logic [5:0]            bcd_o
);
    always_comb begin
        bcd_o = '0;
        for (int i = 0; i < PUNCH_ROWS; i++)
            if (col_i[i]) bcd_o = bcd_o | row_weight(i);
    end
endmodule

// File: rtl/punch_word_collector.sv
module punch_word_collector
    import punch_pkg::*;
#(
    parameter int WORD_W    = 36,
    parameter int NWORDS    = 24,
    parameter int START_DLY = 35000,
    parameter int STOP_DLY  = 35000,
    parameter int SHORT_DLY = 150,
    parameter int LONG_DLY  = 15500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_valid_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              wr_eor_i,
    input  logic              conn_i,
    output logic              req_o,
    output logic              eor_o,
    output logic              ioc_o,
    output logic              ierr_o,
    output logic              col_valid_o,
    output logic [$clog2((NWORDS / PUNCH_ROWS) * WORD_W)-1:0] col_idx_o,
    output logic [PUNCH_ROWS-1:0] col_bin_o,
    output logic [5:0]        col_bcd_o
);
    localparam int HALVES = NWORDS / PUNCH_ROWS;
    localparam int COLS   = HALVES * WORD_W;
    localparam int CIW    = $clog2(COLS);
    localparam int WIW    = $clog2(NWORDS);
    localparam int PW     = $clog2(NWORDS + 1);
    localparam int DMAX_A = (START_DLY > STOP_DLY) ? START_DLY : STOP_DLY;
    localparam int DMAX_B = (SHORT_DLY > LONG_DLY) ? SHORT_DLY : LONG_DLY;
    localparam int DMAX   = (DMAX_A > DMAX_B) ? DMAX_A : DMAX_B;
    localparam int TW     = $clog2(DMAX + 1);

    punch_state_e   state_q, state_d;
    logic [PW-1:0]  ptr_q;
    logic           hold_v_q;
    logic           ioc_q, req_q, eor_q, ierr_q;
    logic           scan_act_q;
    logic [CIW-1:0] scan_col_q;

    logic           tmr_zero, tmr_load, tmr_hold;
    logic [TW-1:0]  tmr_val;

    logic do_init, in_data, wr_hit, last_word, close_wr, close_dc, slot, closing;

    // decoded events of the current cycle
    always_comb begin
        in_data   = (state_q == ST_DATA);
        do_init   = (state_q == ST_START) && tmr_zero;
        wr_hit    = in_data && wr_valid_i;
        last_word = (ptr_q == PW'(NWORDS - 1));
        close_wr  = wr_hit && (last_word || wr_eor_i);
        close_dc  = in_data && !wr_valid_i && !conn_i;
        slot      = in_data && !wr_valid_i && conn_i && tmr_zero;
        closing   = close_wr || close_dc;
    end

    // transitions and timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (sel_i) begin
                    state_d  = ST_START;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(START_DLY - 1);
                end
            end
            ST_START: begin
                if (tmr_zero) begin
                    state_d  = ST_DATA;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SHORT_DLY - 1);
                end
            end
            ST_DATA: begin
                if (closing) begin
                    state_d  = ST_END;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(STOP_DLY - 1);
                end else if (slot) begin
                    tmr_load = 1'b1;
                    tmr_val  = ptr_q[0] ? TW'(SHORT_DLY - 1) : TW'(LONG_DLY - 1);
                end
            end
            ST_END: begin
                if (tmr_zero) begin
                    if (conn_i) begin
                        state_d  = ST_START;
                        tmr_load = 1'b1;
                        tmr_val  = '0;
                    end else begin
                        state_d  = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
        tmr_hold = wr_hit || (state_q == ST_IDLE);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and data-path state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q      <= '0;
            hold_v_q   <= 1'b0;
            ioc_q      <= 1'b0;
            req_q      <= 1'b0;
            eor_q      <= 1'b0;
            ierr_q     <= 1'b0;
            scan_act_q <= 1'b0;
            scan_col_q <= '0;
        end else begin
            req_q  <= do_init || slot;
            eor_q  <= close_wr;
            ierr_q <= wr_valid_i && !in_data;
            if (do_init) begin
                ptr_q    <= '0;
                hold_v_q <= 1'b0;
            end else if (wr_hit) begin
                ptr_q    <= ptr_q + 1'b1;
                hold_v_q <= 1'b1;
            end else if (slot) begin
                hold_v_q <= 1'b0;
                if (!hold_v_q) ioc_q <= 1'b1;
            end
            if (closing) begin
                scan_act_q <= 1'b1;
                scan_col_q <= '0;
            end else if (scan_act_q) begin
                if (scan_col_q == CIW'(COLS - 1)) scan_act_q <= 1'b0;
                else                              scan_col_q <= scan_col_q + 1'b1;
            end
        end
    end

    pc_slot_timer #(.W(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .hold_i     (tmr_hold),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    pc_card_buffer #(.WORD_W(WORD_W), .NWORDS(NWORDS), .ROWS(PUNCH_ROWS)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (do_init),
        .we_i    (wr_hit),
        .widx_i  (ptr_q[WIW-1:0]),
        .wdata_i (wr_data_i),
        .col_i   (scan_col_q),
        .rows_o  (col_bin_o)
    );

    pc_bcd_encoder u_enc (
        .col_i (col_bin_o),
        .bcd_o (col_bcd_o)
    );

    assign req_o       = req_q;
    assign eor_o       = eor_q;
    assign ioc_o       = ioc_q;
    assign ierr_o      = ierr_q;
    assign col_valid_o = scan_act_q;
    assign col_idx_o   = scan_col_q;

    // R2
    req_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (state_q == ST_DATA));
    // R4
    eor_in_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eor_o |-> (state_q == ST_END));
    // R5
    ioc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ioc_o |=> ioc_o);
    // R7
    dc_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && !wr_valid_i && !conn_i) |=> (state_q == ST_END && !eor_o));
    // R9
    col_in_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid_o |-> (state_q == ST_END));
    // R11
    ierr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && state_q != ST_DATA) |=> ierr_o);

endmodule

// File: tb/sim_punch_word_collector.sv
`timescale 1ns/1ps
module sim_punch_word_collector;
    localparam int START_DLY = 20;
    localparam int STOP_DLY  = 90;
    localparam int SHORT_DLY = 3;
    localparam int LONG_DLY  = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr_valid = 1'b0;
    logic [35:0] wr_data = '0;
    logic        wr_eor = 1'b0;
    logic        conn = 1'b0;
    logic        req_o, eor_o, ioc_o, ierr_o, col_valid_o;
    logic [6:0]  col_idx_o;
    logic [11:0] col_bin_o;
    logic [5:0]  col_bcd_o;

    always #4 clk = ~clk;

    punch_word_collector #(
        .START_DLY(START_DLY), .STOP_DLY(STOP_DLY),
        .SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .wr_valid_i(wr_valid),
        .wr_data_i(wr_data), .wr_eor_i(wr_eor), .conn_i(conn),
        .req_o(req_o), .eor_o(eor_o), .ioc_o(ioc_o), .ierr_o(ierr_o),
        .col_valid_o(col_valid_o), .col_idx_o(col_idx_o),
        .col_bin_o(col_bin_o), .col_bcd_o(col_bcd_o)
    );

    // ---------------- behavioural reference ----------------
    int          m_st, m_tmr, m_ptr, m_col;
    bit          m_hv, m_ioc, m_req, m_eor, m_ierr, m_scan;
    logic [35:0] m_buf [0:23];

    function automatic logic [5:0] ref_bcd(input logic [11:0] b);
        logic [5:0] v = '0;
        for (int d = 1; d <= 9; d++) if (b[9 - d]) v = v | 6'(d);
        if (b[9])  v = v | 6'o20;
        if (b[10]) v = v | 6'o40;
        if (b[11]) v = v | 6'o60;
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_tmr <= 0; m_ptr <= 0; m_col <= 0;
            m_hv <= 0; m_ioc <= 0; m_req <= 0; m_eor <= 0; m_ierr <= 0; m_scan <= 0;
            for (int i = 0; i < 24; i++) m_buf[i] <= '0;
        end else begin
            m_req  <= 0;
            m_eor  <= 0;
            m_ierr <= wr_valid && (m_st != 2);
            if (m_scan) begin
                if (m_col == 71) m_scan <= 0;
                else             m_col  <= m_col + 1;
            end
            case (m_st)
                0: if (sel) begin m_st <= 1; m_tmr <= START_DLY - 1; end
                1: if (m_tmr == 0) begin
                       for (int i = 0; i < 24; i++) m_buf[i] <= '0;
                       m_ptr <= 0; m_hv <= 0; m_req <= 1;
                       m_tmr <= SHORT_DLY - 1; m_st <= 2;
                   end else m_tmr <= m_tmr - 1;
                2: if (wr_valid) begin
                       m_buf[m_ptr] <= wr_data;
                       m_ptr <= m_ptr + 1;
                       m_hv  <= 1;
                       if (m_ptr == 23 || wr_eor) begin
                           m_eor <= 1; m_st <= 3; m_tmr <= STOP_DLY - 1;
                           m_scan <= 1; m_col <= 0;
                       end
                   end else if (!conn) begin
                       m_st <= 3; m_tmr <= STOP_DLY - 1; m_scan <= 1; m_col <= 0;
                   end else if (m_tmr == 0) begin
                       if (!m_hv) m_ioc <= 1;
                       m_hv  <= 0;
                       m_req <= 1;
                       m_tmr <= (m_ptr % 2 == 1) ? SHORT_DLY - 1 : LONG_DLY - 1;
                   end else m_tmr <= m_tmr - 1;
                default: if (m_tmr == 0) begin
                       if (conn) begin m_st <= 1; m_tmr <= 0; end
                       else m_st <= 0;
                   end else m_tmr <= m_tmr - 1;
            endcase
        end
    end

    // ---------------- per-cycle compare and channel driver ----------------
    int     cyc_tot = 0, cyc_bad = 0;
    longint req_cnt = 0, wr_cnt = 0, eor_cnt = 0, ierr_cnt = 0, cols_seen = 0, cyc = 0;
    longint req_time [0:255];
    int     force_ack = 0;
    logic [11:0] c0_bin = '0;
    logic [5:0]  c0_bcd = '0;

    // controls written only by the scenario
    int     force_req = 0;
    bit     auto_resp = 0, pat_mode = 0;
    longint skip_lo = -1, skip_hi = -1, eor_at = -1, card_base = 0;

    task automatic cyc_chk(input string tag, input longint act, input longint exp);
        cyc_tot++;
        if (act != exp) begin
            cyc_bad++;
            $display("FAIL %s cycle %0d act=%0h exp=%0h", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        longint idx;
        logic [11:0] eb;
        longint k;
        cyc++;
        if (rst_n) begin
            cyc_chk("R6 req", req_o, m_req);
            cyc_chk("R4 eor", eor_o, m_eor);
            cyc_chk("R5 ioc", ioc_o, m_ioc);
            cyc_chk("R11 ierr", ierr_o, m_ierr);
            cyc_chk("R9 colvalid", col_valid_o, m_scan);
            if (m_scan) begin
                for (int r = 0; r < 12; r++) eb[r] = m_buf[2 * r + m_col / 36][35 - m_col % 36];
                cyc_chk("R9 colidx", col_idx_o, m_col);
                cyc_chk("R3 R9 colbin", col_bin_o, eb);
                cyc_chk("R10 colbcd", col_bcd_o, ref_bcd(eb));
            end
            if (eor_o)  eor_cnt++;
            if (ierr_o) ierr_cnt++;
            if (col_valid_o) begin
                cols_seen++;
                if (col_idx_o == 0) begin c0_bin = col_bin_o; c0_bcd = col_bcd_o; end
            end
        end
        idx = req_cnt;
        if (req_o) begin req_time[idx % 256] = cyc; req_cnt++; end
        wr_valid = 0;
        wr_eor   = 0;
        if (force_req != force_ack) begin
            force_ack = force_req;
            wr_valid  = 1;
            wr_data   = 36'h5_5555_5555;
        end else if (auto_resp && req_o && !(idx >= skip_lo && idx <= skip_hi)) begin
            k = wr_cnt - card_base;
            wr_valid = 1;
            if (pat_mode) wr_data = (k == 0 || k == 22) ? 36'h8_0000_0000 : 36'h0;
            else          wr_data = 36'h9_A5C3_1E7B ^ (36'(wr_cnt) * 36'h1_0F0F_3C3D);
            wr_eor = (wr_cnt == eor_at);
            wr_cnt++;
        end
    end

    // ---------------- scenario ----------------
    int dir_tot = 0, dir_bad = 0;
    bit wd = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        dir_tot++;
        if (act != exp) begin
            dir_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_sel();
        @(negedge clk); sel = 1;
        @(negedge clk); sel = 0;
    endtask

    task automatic run_all();
        longint e0, w0, r0, c0, i0, k;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 req", req_o, 0); chk("R1 eor", eor_o, 0); chk("R1 ioc", ioc_o, 0);
        chk("R1 ierr", ierr_o, 0); chk("R1 colvalid", col_valid_o, 0);
        @(negedge clk); rst_n = 1; conn = 1;
        repeat (2) @(negedge clk);
        // R11 write while idle
        i0 = ierr_cnt; force_req++;
        repeat (4) @(negedge clk);
        chk("R11 ierr pulses", ierr_cnt - i0, 1);
        chk("R11 nothing requested", req_cnt, 0);

        // card 1: full 24 words, column pattern
        pat_mode = 1; card_base = wr_cnt; auto_resp = 1; r0 = req_cnt;
        e0 = eor_cnt; c0 = cols_seen;
        pulse_sel();
        while (m_st != 2) @(negedge clk);
        repeat (3) @(negedge clk);
        pulse_sel();   // R2 ignored while busy
        while (eor_cnt == e0) @(negedge clk);
        chk("R4 full card words", wr_cnt - card_base, 24);
        chk("R6 gap first", req_time[(r0 + 1) % 256] - req_time[r0 % 256], SHORT_DLY + 1);
        chk("R6 gap odd ptr", req_time[(r0 + 2) % 256] - req_time[(r0 + 1) % 256], SHORT_DLY + 1);
        chk("R6 gap even ptr", req_time[(r0 + 3) % 256] - req_time[(r0 + 2) % 256], LONG_DLY + 1);
        repeat (80) @(negedge clk);
        chk("R9 column count", cols_seen - c0, 72);
        chk("R9 column 0 rows", c0_bin, 12'h801);
        chk("R10 column 0 bcd", c0_bcd, 6'o71);
        chk("R5 no miss on time", ioc_o, 0);
        // card 2: restart while connected, record end on fifth word
        pat_mode = 0; e0 = eor_cnt; w0 = wr_cnt; r0 = req_cnt;
        eor_at = wr_cnt + 4;
        repeat (STOP_DLY) @(negedge clk);
        chk("R8 restart requested", (req_cnt > r0) ? 1 : 0, 1);
        while (eor_cnt == e0) @(negedge clk);
        chk("R4 record-end words", wr_cnt - w0, 5);
        conn = 0; r0 = req_cnt;
        repeat (STOP_DLY + 20) @(negedge clk);
        chk("R8 no restart when disconnected", req_cnt - r0, 0);

        // card 3: start delay, missed slots, disconnect
        conn = 1; eor_at = -1; skip_lo = req_cnt + 2; skip_hi = req_cnt + 3;
        e0 = eor_cnt; w0 = wr_cnt;
        @(negedge clk); sel = 1;
        @(negedge clk); sel = 0;
        k = 0;
        while (!req_o) begin @(negedge clk); k++; end
        chk("R2 start delay", k, START_DLY);
        while (wr_cnt < w0 + 8) @(negedge clk);
        @(negedge clk); conn = 0;
        repeat (5) @(negedge clk);
        chk("R7 no eor on disconnect", eor_cnt - e0, 0);
        chk("R5 ioc after miss", ioc_o, 1);
        repeat (STOP_DLY + 20) @(negedge clk);
        chk("R5 ioc sticky", ioc_o, 1);
        chk("R7 columns streamed", (m_st == 0) ? 1 : 0, 1);
    endtask

    initial begin
        fork
            run_all();
            begin repeat (20000) @(posedge clk); wd = 1; end
        join_any
        disable fork;
        if (wd) begin
            dir_tot++; dir_bad++;
            $display("FAIL watchdog act=timeout exp=finished");
        end
        $display("test done: total=%0d bad=%0d", cyc_tot + dir_tot, cyc_bad + dir_bad);
        $finish;
    end

endmodule